// File: doc/BRIEF.md
# Tone-Pair Steering Guard and Key Code Latch

This block sits behind a dual-tone frequency detector and decides when a detected key press is real. The detector supplies a flag that is high while two valid tones are heard, plus the 2-bit row and column indices of the pair. The block times that flag with digital counters in place of an analog RC network. A pair is accepted only when the flag stays high for a programmable presence guard. It is released only when the flag stays low for a separate programmable absence guard, so short dropouts inside one key press are bridged.

On acceptance the pair is translated to a 4-bit key code and stored in a latch. A ready flag rises a fixed number of settle ticks later, so a consumer that reacts to the flag always sees stable data. The latch keeps its code after the tone ends, until the next accepted pair. An input can block the fourth column of keys. The code bus has an output enable, and a drive indication is provided for the pad.

Top module: `tone_steer`

## Requirements
- R1: A pair is accepted at the rising edge where the qualified flag has been sampled high on `present_ticks` consecutive edges. A shorter burst, or a burst broken by a single low sample, changes neither the latch nor `code_ready`.
- R2: After acceptance, release happens at the edge where the qualified flag has been sampled low on `absent_ticks` consecutive edges. A shorter dropout leaves `code_ready` high and the code unchanged, and the absence count starts over once the flag is high again.
- R3: Row index 0..3 selects the 697/770/852/941 Hz tone and column index 0..3 selects the 1209/1336/1477/1633 Hz tone. The keys are row 0: 1,2,3,A; row 1: 4,5,6,B; row 2: 7,8,9,C; row 3: *,0,#,D. The codes are 1..9 for digits 1..9, 0 as 4'b1010, * as 4'b1011, # as 4'b1100, A as 4'b1101, B as 4'b1110, C as 4'b1111 and D as 4'b0000.
- R4: While `block_fourth` is high, a pair with column index 3 is treated as no tone. It is never accepted and the previous code stays latched. Pairs in other columns are still accepted.
- R5: While `bus_oe` is low, `key_code` is high impedance and `bus_drive` is 0. The latch keeps updating, and the stored value appears on `key_code` as soon as `bus_oe` is high.
- R6: `code_ready` rises SETTLE_TICKS rising edges after the edge that updates the latch and falls at the release edge. If the release comes first, it does not rise for that pair.
- R7: The latched code stays unchanged after release until the next pair is accepted.
- R8: Both guard times are taken from ports in clock ticks at run time. A value of 0 acts as 1.
- R9: A synchronous active-high reset clears the latch to 4'b0000, drops `code_ready` and returns to the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tone_seen | input | 1 | Flag from the detector: a valid tone pair is heard |
| row_sel | input | 2 | Row index of the detected pair |
| col_sel | input | 2 | Column index of the detected pair |
| block_fourth | input | 1 | High blocks acceptance of column-3 keys |
| present_ticks | input | CNT_W | Presence guard in clock ticks |
| absent_ticks | input | CNT_W | Absence guard in clock ticks |
| bus_oe | input | 1 | Output enable for the code bus |
| key_code | output | 4 | Latched key code, high impedance when disabled |
| bus_drive | output | 1 | High while the code bus is driven |
| code_ready | output | 1 | Delayed steering flag: a latched code is valid |

## Verification
Take P as the presence guard, A as the absence guard and S as SETTLE_TICKS. The new code is due after the P-th rising edge with the flag high. `code_ready` is due S edges later and drops on the A-th edge with the flag low. The bench drives inputs on falling edges and counts rising edges with a step task. It samples one edge short of each due point and again at the point itself, so both an early and a late response are caught. The enable path is combinational and is sampled in the same low phase in which `bus_oe` changes.

// File: rtl/tone_steer_pkg.sv
package tone_steer_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_PRESENT = 2'd1,
      ST_HELD    = 2'd2,
      ST_ABSENT  = 2'd3
   } steer_state_t;

   // row: low-group tone index, col: high-group tone index
   function automatic logic [3:0] pair_to_code(input logic [1:0] row, input logic [1:0] col);
      logic [3:0] res;
      if (col == 2'd3) begin
         res = 4'd13 + {2'b00, row};          // A,B,C then D wraps to 0
      end else if (row == 2'd3) begin
         case (col)
            2'd0:    res = 4'd11;             // *
            2'd1:    res = 4'd10;             // 0
            default: res = 4'd12;             // #
         endcase
      end else begin
         res = 4'd1 + ({2'b00, row} * 4'd3) + {2'b00, col};
      end
      return res;
   endfunction

endpackage

// File: rtl/tone_guard_timer.sv
module tone_guard_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             hit
);
   localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   nxt;
   logic [CNT_W:0]   lim_eff;

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("tone_guard_timer: CNT_W must be at least 1");
      end
   endgenerate

   always_comb begin
      nxt     = {1'b0, cnt_q} + ONE;
      lim_eff = (limit == '0) ? ONE : {1'b0, limit};
      hit     = run && (nxt >= lim_eff);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (run && !hit) begin
         cnt_q <= nxt[CNT_W-1:0];
      end else begin
         cnt_q <= '0;
      end
   end

   // R8: a running count never passes the programmed limit while it is held
   p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
      (run && !$past(rst) && $stable(limit) && limit != '0) |-> ({1'b0, cnt_q} < {1'b0, limit}));

endmodule

// File: rtl/tone_code_map.sv
module tone_code_map
   import tone_steer_pkg::*;
(
   input  logic [1:0] row,
   input  logic [1:0] col,
   output logic [3:0] code
);
   localparam int KEYS = 16;

   logic [3:0] table_w [KEYS];

   generate
      for (genvar gi = 0; gi < KEYS; gi++) begin : g_key
         localparam logic [3:0] IDX = gi[3:0];
         assign table_w[gi] = pair_to_code(IDX[3:2], IDX[1:0]);
      end
   endgenerate

   assign code = table_w[{row, col}];

endmodule

// File: rtl/tone_settle.sv
module tone_settle #(
   parameter int SETTLE_TICKS = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic cancel,
   output logic ready
);
   generate
      if (SETTLE_TICKS < 0) begin : g_bad_settle
         $error("tone_settle: SETTLE_TICKS must not be negative");
      end

      if (SETTLE_TICKS == 0) begin : g_direct
         always_ff @(posedge clk) begin
            if (rst || cancel) begin
               ready <= 1'b0;
            end else if (start) begin
               ready <= 1'b1;
            end
         end
      end else begin : g_delayed
         localparam int SW = $clog2(SETTLE_TICKS + 1);
         localparam logic [SW-1:0] LOAD = SW'(SETTLE_TICKS);
         logic [SW-1:0] left_q;

         always_ff @(posedge clk) begin
            if (rst || cancel) begin
               left_q <= '0;
               ready  <= 1'b0;
            end else if (start) begin
               left_q <= LOAD;
               ready  <= 1'b0;
            end else if (left_q != '0) begin
               left_q <= left_q - 1'b1;
               if (left_q == SW'(1)) begin
                  ready <= 1'b1;
               end
            end
         end

         // R6: ready never rises while a settle count is still running
         p_ready_after_count_r6: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $rose(ready)) |-> (left_q == '0));
      end
   endgenerate

endmodule

// File: rtl/tone_steer_fsm.sv
module tone_steer_fsm
   import tone_steer_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             qual,
   input  logic [CNT_W-1:0] present_ticks,
   input  logic [CNT_W-1:0] absent_ticks,
   output steer_state_t     state,
   output logic             accept,
   output logic             release_pair
);
   steer_state_t     state_q, state_d;
   logic             waiting_tone;
   logic             run;
   logic             hit;
   logic [CNT_W-1:0] limit;

   assign waiting_tone = (state_q == ST_IDLE) || (state_q == ST_PRESENT);
   assign run          = waiting_tone ? qual : !qual;
   assign limit        = waiting_tone ? present_ticks : absent_ticks;

   tone_guard_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst   (rst),
      .run   (run),
      .limit (limit),
      .hit   (hit)
   );

   always_comb begin
      state_d      = state_q;
      accept       = 1'b0;
      release_pair = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (hit) begin
               state_d = ST_HELD;
               accept  = 1'b1;
            end else if (qual) begin
               state_d = ST_PRESENT;
            end
         end
         ST_PRESENT: begin
            if (hit) begin
               state_d = ST_HELD;
               accept  = 1'b1;
            end else if (!qual) begin
               state_d = ST_IDLE;
            end
         end
         ST_HELD: begin
            if (hit) begin
               state_d      = ST_IDLE;
               release_pair = 1'b1;
            end else if (!qual) begin
               state_d = ST_ABSENT;
            end
         end
         ST_ABSENT: begin
            if (hit) begin
               state_d      = ST_IDLE;
               release_pair = 1'b1;
            end else if (qual) begin
               state_d = ST_HELD;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   assign state = state_q;

   // R1: acceptance only with the flag high
   p_accept_needs_tone_r1: assert property (@(posedge clk) disable iff (rst)
      accept |-> qual);

   // R2: release only with the flag low
   p_release_needs_silence_r2: assert property (@(posedge clk) disable iff (rst)
      release_pair |-> !qual);

   // R2: a high flag in the absence window returns to the held state
   p_dropout_bridged_r2: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_ABSENT && qual) |=> (state_q == ST_HELD));

endmodule

// File: rtl/tone_steer.sv
module tone_steer
   import tone_steer_pkg::*;
#(
   parameter int CNT_W        = 8,
   parameter int SETTLE_TICKS = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tone_seen,
   input  logic [1:0]       row_sel,
   input  logic [1:0]       col_sel,
   input  logic             block_fourth,
   input  logic [CNT_W-1:0] present_ticks,
   input  logic [CNT_W-1:0] absent_ticks,
   input  logic             bus_oe,
   output logic [3:0]       key_code,
   output logic             bus_drive,
   output logic             code_ready
);
   localparam logic [1:0] FOURTH_COL = 2'd3;

   steer_state_t state;
   logic         qual;
   logic         accept;
   logic         release_pair;
   logic [3:0]   mapped;
   logic [3:0]   latch_q;

   generate
      if (CNT_W > 24) begin : g_bad_cnt
         $error("tone_steer: CNT_W above 24 is not supported");
      end
   endgenerate

   assign qual = tone_seen && !(block_fourth && (col_sel == FOURTH_COL));

   tone_steer_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk           (clk),
      .rst           (rst),
      .qual          (qual),
      .present_ticks (present_ticks),
      .absent_ticks  (absent_ticks),
      .state         (state),
      .accept        (accept),
      .release_pair  (release_pair)
   );

   tone_code_map u_map (
      .row  (row_sel),
      .col  (col_sel),
      .code (mapped)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         latch_q <= 4'b0000;
      end else if (accept) begin
         latch_q <= mapped;
      end
   end

   tone_settle #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
      .clk    (clk),
      .rst    (rst),
      .start  (accept),
      .cancel (release_pair),
      .ready  (code_ready)
   );

   assign bus_drive = bus_oe;
   assign key_code  = bus_oe ? latch_q : 4'bzzzz;

   // R7: the latch moves only on the edge after an acceptance
   p_latch_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && latch_q != $past(latch_q)) |-> $past(accept));

   // R4: a blocked fourth-column pair is never accepted
   p_block_fourth_r4: assert property (@(posedge clk) disable iff (rst)
      (block_fourth && col_sel == FOURTH_COL) |-> !accept);

   // R6: ready only while a pair is held
   p_ready_in_hold_r6: assert property (@(posedge clk) disable iff (rst)
      code_ready |-> (state == ST_HELD || state == ST_ABSENT));

   // R5: a disabled bus keeps the stored value when nothing is accepted
   p_oe_keeps_latch_r5: assert property (@(posedge clk) disable iff (rst)
      (!bus_oe && !accept) |=> $stable(latch_q));

endmodule

// File: tb/tone_steer_bench.sv
`timescale 1ns/1ps
module tone_steer_bench;
   localparam int CNT_W = 8;
   localparam int S     = 3;
   localparam int P     = 5;
   localparam int A     = 4;

   logic             clk = 1'b0;
   logic             rst;
   logic             tone_seen;
   logic [1:0]       row_sel;
   logic [1:0]       col_sel;
   logic             block_fourth;
   logic [CNT_W-1:0] present_ticks;
   logic [CNT_W-1:0] absent_ticks;
   logic             bus_oe;
   logic [3:0]       key_code;
   logic             bus_drive;
   logic             code_ready;

   int checks   = 0;
   int failures = 0;
   logic [3:0] prev;

   always #4 clk = ~clk;

   tone_steer #(.CNT_W(CNT_W), .SETTLE_TICKS(S)) u_tone_steer (
      .clk           (clk),
      .rst           (rst),
      .tone_seen     (tone_seen),
      .row_sel       (row_sel),
      .col_sel       (col_sel),
      .block_fourth  (block_fourth),
      .present_ticks (present_ticks),
      .absent_ticks  (absent_ticks),
      .bus_oe        (bus_oe),
      .key_code      (key_code),
      .bus_drive     (bus_drive),
      .code_ready    (code_ready)
   );

   function automatic logic [3:0] expect_code(input int r, input int c);
      if (c == 3)      return 4'((13 + r) % 16);
      if (r == 3)      return (c == 0) ? 4'd11 : (c == 1) ? 4'd10 : 4'd12;
      return 4'(3 * r + c + 1);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic press(input int r, input int c);
      tone_seen = 1'b1;
      row_sel   = 2'(r);
      col_sel   = 2'(c);
   endtask

   task automatic quiet();
      tone_seen = 1'b0;
   endtask

   initial begin
      #2_000_000;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst = 1'b1; tone_seen = 1'b0; row_sel = '0; col_sel = '0;
      block_fourth = 1'b0; present_ticks = 8'(P); absent_ticks = 8'(A); bus_oe = 1'b1;
      step(3);
      rst = 1'b0;
      step(1);
      chk("R9 reset code", int'(key_code), 0);
      chk("R9 reset ready", int'(code_ready), 0);
      chk("R5 drive on", int'(bus_drive), 1);
      prev = 4'd0;

      // R3 full sweep of all sixteen pairs with R1/R6/R2/R7 timing
      for (int k = 0; k < 16; k++) begin
         logic [3:0] e;
         e = expect_code(k / 4, k % 4);
         press(k / 4, k % 4);
         step(P - 1);
         chk("R1 before guard", int'(key_code), int'(prev));
         chk("R1 no ready early", int'(code_ready), 0);
         step(1);
         chk("R3 code", int'(key_code), int'(e));
         step(S - 1);
         chk("R6 ready not yet", int'(code_ready), 0);
         step(1);
         chk("R6 ready", int'(code_ready), 1);
         quiet();
         step(A - 1);
         chk("R2 held in absence", int'(code_ready), 1);
         step(1);
         chk("R2 released", int'(code_ready), 0);
         chk("R7 code persists", int'(key_code), int'(e));
         prev = e;
      end

      // R1 short burst and broken burst
      press(1, 1);
      step(P - 1);
      quiet(); step(1);
      press(1, 1); step(P - 1);
      quiet(); step(4);
      chk("R1 broken burst code", int'(key_code), int'(prev));
      chk("R1 broken burst ready", int'(code_ready), 0);

      // R2 dropout bridging
      press(0, 0);
      step(P + S);
      chk("R2 setup ready", int'(code_ready), 1);
      quiet(); step(A - 1);
      press(0, 0); step(1);
      quiet(); step(A - 1);
      chk("R2 dropout bridged", int'(code_ready), 1);
      chk("R2 dropout code", int'(key_code), 1);
      step(1);
      chk("R2 release after full gap", int'(code_ready), 0);
      prev = 4'd1;

      // R4 blocking of the fourth column
      block_fourth = 1'b1;
      press(2, 3);
      step(P + S + 2);
      chk("R4 blocked code", int'(key_code), int'(prev));
      chk("R4 blocked ready", int'(code_ready), 0);
      press(2, 2);
      step(P);
      chk("R4 other column accepted", int'(key_code), 9);
      step(S);
      chk("R4 other column ready", int'(code_ready), 1);
      quiet(); step(A);
      block_fourth = 1'b0;

      // R5 output enable
      bus_oe = 1'b0;
      #1;
      chk("R5 drive off", int'(bus_drive), 0);
      press(3, 0);
      step(P + S);
      chk("R5 ready while disabled", int'(code_ready), 1);
      bus_oe = 1'b1;
      #1;
      chk("R5 value after enable", int'(key_code), 11);
      chk("R5 drive back", int'(bus_drive), 1);
      quiet(); step(A);

      // R6 release before settle completes
      absent_ticks = 8'd1;
      press(0, 1);
      step(P);
      chk("R6 code early release", int'(key_code), 2);
      quiet(); step(1);
      chk("R6 no ready at release", int'(code_ready), 0);
      step(5);
      chk("R6 ready stays low", int'(code_ready), 0);

      // R8 shortest guards and zero treated as one
      present_ticks = 8'd1;
      press(3, 2);
      step(1);
      chk("R8 one-tick accept", int'(key_code), 12);
      step(S - 1);
      chk("R8 ready not yet", int'(code_ready), 0);
      step(1);
      chk("R8 ready", int'(code_ready), 1);
      quiet(); step(1);
      chk("R8 one-tick release", int'(code_ready), 0);
      present_ticks = 8'd0;
      absent_ticks  = 8'd0;
      press(1, 0);
      step(1);
      chk("R8 zero acts as one", int'(key_code), 4);
      quiet(); step(S + 1);
      chk("R8 zero release", int'(code_ready), 0);

      // R9 reset in the middle of a held pair
      present_ticks = 8'(P);
      absent_ticks  = 8'(A);
      press(0, 2);
      step(P + S);
      chk("R9 setup ready", int'(code_ready), 1);
      rst = 1'b1;
      step(1);
      rst = 1'b0;
      quiet();
      chk("R9 code cleared", int'(key_code), 0);
      chk("R9 ready cleared", int'(code_ready), 0);
      step(2);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule